// File: doc/BRIEF.md
# Configuration Load Sequencer

This block is the device-side sequencer of a programmable part that receives its configuration as a serial bit stream. A power-on reset or a filtered, active-low program request starts a fixed sequence. First the user outputs are disabled and the status flags are forced to their configuration values. Next, user state and the configuration store are cleared while the block pulls the shared init line low. The block then samples its mode, waits for its start condition and loads data bits. Finally it brings up the user outputs, the done flag and the internal reset release in a selectable order.

Several devices can share one init line as a wired-AND. A master does not start loading until every device on the chain has released that line. Data arrives one bit per cycle when the strobe is valid, either directly or through an 8-bit parallel-to-serial converter. The block keeps the first `keep_len` bits and forwards the later bits, one cycle late, to the next device on the chain. Startup begins once `total_len` bits have passed through.

Top module: `cfg_load_seq`

## Requirements
- R1: A low level on `rst_n` starts the first configuration. `prog_req_n` starts a reconfiguration from any state, but only after it has been sampled low on FILT_CYC (3) consecutive clock edges. A shorter low pulse has no effect.
- R2: Whenever the block is clearing, `user_oe`=0, `done`=0, `hdc`=1, `ldc`=0 and `int_rst`=1.
- R3: `init_drive_low` is 1 for the whole clear. During the clear, `user_q` and `cfg_q` read zero.
- R4: One clear pass lasts CLR_CYC (8) cycles. The first configuration after power-on lasts 4*CLR_CYC cycles if `mode_n` is low (master). A slave first configuration and every reconfiguration use CLR_CYC.
- R5: While the request stays active, the block keeps clearing. After the request is released, it runs one more full pass and then releases `init_drive_low`. A 4-cycle request pulse therefore gives exactly 2*CLR_CYC cycles of clear.
- R6: The cycle after the clear, `mode_n` is sampled: low selects master. While `start_n` is low, the block waits, `byte_ready` stays 0 and no bit is taken.
- R7: A master leaves the wait only when `init_in` is high, and bits offered before that are ignored. A slave does not look at `init_in`.
- R8: In serial mode (`byte_mode`=0), each cycle with `cfg_bit_valid`=1 takes `cfg_bit`. The first `keep_len` bits shift into `cfg_q` at bit 0, so data bit i ends at `cfg_q[keep_len-1-i]`.
- R9: In byte mode (`byte_mode`=1), a byte is accepted when `byte_valid` and `byte_ready` are both 1. It is then fed in MSB first, one bit per cycle over 8 cycles, and `byte_ready` stays 0 until the last bit of that byte has been taken.
- R10: Bits with index keep_len and above do not change `cfg_q`. Each appears on `dout` with `dout_valid`=1 in the cycle after it was taken, in arrival order.
- R11: After bit `total_len`-1, the block performs three events, one per cycle: raise `user_oe` (which drives `hdc` low and `ldc` high), raise `done`, and release `int_rst`. The order is set by `startup_sel`: 0 gives oe, done, reset; 1 gives done, oe, reset; 2 gives done, reset, oe; 3 gives reset, done, oe. Once `done` is high, `cfg_q` no longer changes.
- R12: After startup, `user_q` loads `user_d` on `user_we`, and only in the operational state. A reconfiguration zeroes it, so no user value survives into the next configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the configuration bit clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| prog_req_n | input | 1 | Program request, active low, filtered |
| mode_n | input | 1 | Low selects master |
| start_n | input | 1 | Low holds the block before loading |
| init_in | input | 1 | Level of the shared wired-AND init line |
| init_drive_low | output | 1 | Pulls the shared init line low while clearing |
| keep_len | input | CNT_W | Bits kept in this device |
| total_len | input | CNT_W | Bits on the whole chain before startup |
| startup_sel | input | 2 | Startup event order code |
| byte_mode | input | 1 | 1 selects the byte interface |
| cfg_bit_valid | input | 1 | Serial bit strobe |
| cfg_bit | input | 1 | Serial data bit |
| byte_valid | input | 1 | Byte offered |
| byte_data | input | 8 | Byte value, sent MSB first |
| byte_ready | output | 1 | Converter can take a byte |
| cfg_q | output | STORE_W | Configuration store |
| dout | output | 1 | Daisy-chain serial output |
| dout_valid | output | 1 | `dout` carries a forwarded bit |
| user_we | input | 1 | User register write enable |
| user_d | input | UW | User register data |
| user_q | output | UW | User register value |
| user_oe | output | 1 | User outputs enabled |
| done | output | 1 | Configuration complete |
| hdc | output | 1 | High while configuring |
| ldc | output | 1 | Low while configuring |
| int_rst | output | 1 | Internal reset, active high |

## Verification
The assertions assume that `keep_len` never exceeds STORE_W, that `total_len` is at least `keep_len` and at least 1, and that `mode_n` and the length inputs stay steady from the start of a clear to the end of startup. The stimulus sets modes and lengths only while the block is operational or held in reset. It offers bytes only when `byte_ready` is seen high, and it builds the bench's `init_in` as the wired-AND of the block's own pull-down and a model of another device.

// File: rtl/cfg_load_seq.sv
`timescale 1ns/1ps
module cfg_load_seq #(
  parameter int STORE_W  = 32,
  parameter int CNT_W    = 16,
  parameter int CLR_CYC  = 8,
  parameter int FILT_CYC = 3,
  parameter int UW       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_req_n,
  input  logic               mode_n,
  input  logic               start_n,
  input  logic               init_in,
  output logic               init_drive_low,
  input  logic [CNT_W-1:0]   keep_len,
  input  logic [CNT_W-1:0]   total_len,
  input  logic [1:0]         startup_sel,
  input  logic               byte_mode,
  input  logic               cfg_bit_valid,
  input  logic               cfg_bit,
  input  logic               byte_valid,
  input  logic [7:0]         byte_data,
  output logic               byte_ready,
  output logic [STORE_W-1:0] cfg_q,
  output logic               dout,
  output logic               dout_valid,
  input  logic               user_we,
  input  logic [UW-1:0]      user_d,
  output logic [UW-1:0]      user_q,
  output logic               user_oe,
  output logic               done,
  output logic               hdc,
  output logic               ldc,
  output logic               int_rst
);
  localparam int CLR_W = $clog2(4*CLR_CYC+1);
  localparam int FW    = $clog2(FILT_CYC+1);

  typedef enum logic [2:0] {S_CLEAR, S_SAMPLE, S_WAIT, S_LOAD, S_START, S_OPER} st_t;

  st_t                st;
  logic [CLR_W-1:0]   clr_cnt;
  logic [FW-1:0]      fcnt;
  logic               req_seen, first_cfg, is_master;
  logic [CNT_W-1:0]   bc;
  logic [7:0]         sh_reg;
  logic [3:0]         sh_cnt;
  logic [1:0]         step;
  logic               oe_r, done_r, rel_r, dout_r, dv_r;
  logic [STORE_W-1:0] store;
  logic [UW-1:0]      ureg;
  logic [1:0]         ev_now;

  wire req_act   = (fcnt == FW'(FILT_CYC));
  wire [CLR_W-1:0] clr_last = (first_cfg && !mode_n) ? CLR_W'(4*CLR_CYC-1) : CLR_W'(CLR_CYC-1);
  wire bit_stb   = (st == S_LOAD) && (byte_mode ? (sh_cnt != 4'd0) : cfg_bit_valid);
  wire bit_val   = byte_mode ? sh_reg[7] : cfg_bit;
  wire keep_hit  = (bc < keep_len);
  wire last_bit  = ((bc + CNT_W'(1)) == total_len);

  assign init_drive_low = (st == S_CLEAR);
  assign byte_ready     = (st == S_LOAD) && byte_mode && (sh_cnt == 4'd0);
  assign cfg_q          = store;
  assign dout           = dout_r;
  assign dout_valid     = dv_r;
  assign user_q         = ureg;
  assign user_oe        = oe_r;
  assign done           = done_r;
  assign hdc            = !oe_r;
  assign ldc            = oe_r;
  assign int_rst        = !rel_r;

  always_comb begin
    case ({startup_sel, step})
      4'b00_00: ev_now = 2'd0;
      4'b00_01: ev_now = 2'd1;
      4'b01_00: ev_now = 2'd1;
      4'b01_01: ev_now = 2'd0;
      4'b10_00: ev_now = 2'd1;
      4'b10_01: ev_now = 2'd2;
      4'b11_00: ev_now = 2'd2;
      4'b11_01: ev_now = 2'd1;
      default:  ev_now = (startup_sel[1]) ? ((startup_sel[0]) ? 2'd0 : 2'd0) : 2'd2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fcnt <= '0;
    else if (prog_req_n) fcnt <= '0;
    else if (!req_act) fcnt <= fcnt + FW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_CLEAR; clr_cnt <= '0; req_seen <= 1'b0; first_cfg <= 1'b1; is_master <= 1'b0;
      bc <= '0; sh_reg <= '0; sh_cnt <= '0; step <= '0;
      oe_r <= 1'b0; done_r <= 1'b0; rel_r <= 1'b0; dout_r <= 1'b0; dv_r <= 1'b0;
      store <= '0; ureg <= '0;
    end else begin
      dv_r <= 1'b0;
      case (st)
        S_CLEAR: begin
          oe_r <= 1'b0; done_r <= 1'b0; rel_r <= 1'b0;
          store <= '0; ureg <= '0; bc <= '0; sh_cnt <= '0; step <= '0;
          if (clr_cnt == clr_last) begin
            clr_cnt <= '0;
            if (req_act) req_seen <= 1'b1;
            else if (req_seen) req_seen <= 1'b0;
            else begin
              st <= S_SAMPLE;
              first_cfg <= 1'b0;
            end
          end else begin
            clr_cnt <= clr_cnt + CLR_W'(1);
            if (req_act) req_seen <= 1'b1;
          end
        end
        S_SAMPLE: begin
          is_master <= !mode_n;
          st <= S_WAIT;
        end
        S_WAIT: if (start_n && (!is_master || init_in)) st <= S_LOAD;
        S_LOAD: begin
          if (byte_mode && sh_cnt == 4'd0 && byte_valid) begin
            sh_reg <= byte_data;
            sh_cnt <= 4'd8;
          end else if (byte_mode && sh_cnt != 4'd0) begin
            sh_reg <= {sh_reg[6:0], 1'b0};
            sh_cnt <= sh_cnt - 4'd1;
          end
          if (bit_stb) begin
            if (keep_hit) store <= {store[STORE_W-2:0], bit_val};
            else begin
              dout_r <= bit_val;
              dv_r   <= 1'b1;
            end
            bc <= bc + CNT_W'(1);
            if (last_bit) begin
              st <= S_START;
              step <= '0;
            end
          end
        end
        S_START: begin
          case (ev_now)
            2'd0:    oe_r   <= 1'b1;
            2'd1:    done_r <= 1'b1;
            default: rel_r  <= 1'b1;
          endcase
          step <= step + 2'd1;
          if (step == 2'd2) st <= S_OPER;
        end
        S_OPER: if (user_we) ureg <= user_d;
        default: st <= S_CLEAR;
      endcase
      if (req_act && st != S_CLEAR) begin
        st <= S_CLEAR; clr_cnt <= '0; req_seen <= 1'b1; first_cfg <= 1'b0;
        oe_r <= 1'b0; done_r <= 1'b0; rel_r <= 1'b0; dv_r <= 1'b0;
        store <= '0; ureg <= '0; sh_cnt <= '0; bc <= '0;
      end
    end
  end

  a_r2_cfg_flags: assert property (@(posedge clk) disable iff (!rst_n)
    init_drive_low |-> (!user_oe && !done && hdc && !ldc && int_rst));
  a_r3_user_clear: assert property (@(posedge clk) disable iff (!rst_n)
    init_drive_low |-> (user_q == '0 && cfg_q == '0));
  a_r5_req_holds_init: assert property (@(posedge clk) disable iff (!rst_n)
    req_act |=> init_drive_low);
  a_r7_master_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && $past(st) == S_WAIT && is_master) |-> $past(init_in));
  a_r9_byte_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && byte_ready) |=> !byte_ready);
  a_r10_fwd_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> ($past(st) == S_LOAD));
  a_r11_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $stable(cfg_q));
endmodule

// File: tb/sim_cfg_load_seq.sv
`timescale 1ns/1ps
module sim_cfg_load_seq;
  localparam int STORE_W = 32, CNT_W = 16, CLR = 8, FILT = 3, UW = 8;

  logic clk = 1'b0, rst_n = 1'b0, prog_req_n = 1'b1, mode_n = 1'b0, start_n = 1'b1;
  logic other_low = 1'b0, init_drive_low, init_in;
  logic [CNT_W-1:0] keep_len = '0, total_len = 16'd1;
  logic [1:0] startup_sel = 2'd0;
  logic byte_mode = 1'b0, cfg_bit_valid = 1'b0, cfg_bit = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready, dout, dout_valid, user_we = 1'b0, user_oe, done, hdc, ldc, int_rst;
  logic [UW-1:0] user_d = '0, user_q;
  logic [STORE_W-1:0] cfg_q;

  int errors = 0, checks = 0, n = 0, bidx = 0;
  bit exp_q[$];

  always #10 clk = ~clk;
  assign init_in = !init_drive_low && !other_low;

  cfg_load_seq #(.STORE_W(STORE_W), .CNT_W(CNT_W), .CLR_CYC(CLR), .FILT_CYC(FILT), .UW(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_req_n(prog_req_n), .mode_n(mode_n), .start_n(start_n),
    .init_in(init_in), .init_drive_low(init_drive_low), .keep_len(keep_len), .total_len(total_len),
    .startup_sel(startup_sel), .byte_mode(byte_mode), .cfg_bit_valid(cfg_bit_valid), .cfg_bit(cfg_bit),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready), .cfg_q(cfg_q),
    .dout(dout), .dout_valid(dout_valid), .user_we(user_we), .user_d(user_d), .user_q(user_q),
    .user_oe(user_oe), .done(done), .hdc(hdc), .ldc(ldc), .int_rst(int_rst));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dout_valid) begin
      if (exp_q.size() == 0) chk("R10 unexpected forwarded bit", 1, 0);
      else chk("R10 forwarded bit", dout, exp_q.pop_front());
    end
  end

  task automatic count_clear(output int cnt);
    cnt = 0;
    while (init_drive_low && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic send_ser(input logic [63:0] v, input int nb, input int keep, input bit live);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      cfg_bit_valid = 1'b1;
      cfg_bit = v[nb-1-i];
      if (live && i >= keep) exp_q.push_back(v[nb-1-i]);
    end
    @(negedge clk);
    cfg_bit_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int keep, input int total);
    int w = 0;
    @(negedge clk);
    while (!byte_ready && w < 100) begin w++; @(negedge clk); end
    byte_valid = 1'b1;
    byte_data = b;
    for (int j = 7; j >= 0; j--) begin
      if (bidx >= keep && bidx < total) exp_q.push_back(b[j]);
      bidx++;
    end
    @(negedge clk);
    byte_valid = 1'b0;
    chk("R9 byte_ready low while shifting", byte_ready, 0);
  endtask

  task automatic watch_startup(input int sel);
    int k_oe = -1, k_dn = -1, k_rs = -1, base;
    int p_oe, p_dn, p_rs;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (user_oe && k_oe < 0) k_oe = k;
      if (done && k_dn < 0) k_dn = k;
      if (!int_rst && k_rs < 0) k_rs = k;
      if (k_oe >= 0 && k_dn >= 0 && k_rs >= 0) break;
    end
    base = k_oe;
    if (k_dn < base) base = k_dn;
    if (k_rs < base) base = k_rs;
    case (sel)
      0: begin p_oe = 0; p_dn = 1; p_rs = 2; end
      1: begin p_oe = 1; p_dn = 0; p_rs = 2; end
      2: begin p_oe = 2; p_dn = 0; p_rs = 1; end
      default: begin p_oe = 2; p_dn = 1; p_rs = 0; end
    endcase
    chk("R11 oe position", k_oe - base, p_oe);
    chk("R11 done position", k_dn - base, p_dn);
    chk("R11 reset release position", k_rs - base, p_rs);
    chk("R11 hdc low after startup", hdc, 0);
    chk("R11 ldc high after startup", ldc, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 done in reset", done, 0);
    chk("R2 hdc in reset", hdc, 1);
    chk("R2 ldc in reset", ldc, 0);
    chk("R2 oe/int_rst in reset", {user_oe, int_rst}, 2'b01);
    chk("R3 init low in reset", init_drive_low, 1);
    keep_len = 16'd12; total_len = 16'd20; startup_sel = 2'd0;
    other_low = 1'b1;
    rst_n = 1'b1;
    count_clear(n);
    chk("R4 master power-up clear length", n, 4*CLR);
    user_we = 1'b1; user_d = 8'h77;
    send_ser(64'h1F, 5, 0, 1'b0);
    user_we = 1'b0;
    chk("R7 bits before init high ignored", cfg_q, 0);
    chk("R12 user write outside operation ignored", user_q, 0);
    @(negedge clk); other_low = 1'b0;
    repeat (2) @(negedge clk);
    send_ser(64'hC3A59, 20, 12, 1'b1);
    watch_startup(0);
    chk("R8 serial store", cfg_q, 32'hC3A);
    chk("R10 queue drained", exp_q.size(), 0);

    @(negedge clk); user_we = 1'b1; user_d = 8'hA5;
    @(negedge clk); user_we = 1'b0;
    chk("R12 user write in operation", user_q, 8'hA5);
    @(negedge clk); prog_req_n = 1'b0;
    repeat (FILT-1) @(negedge clk); prog_req_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 short pulse keeps done", done, 1);
    chk("R1 short pulse keeps user value", user_q, 8'hA5);
    chk("R1 short pulse no clear", init_drive_low, 0);

    start_n = 1'b0; byte_mode = 1'b1; keep_len = 16'd16; total_len = 16'd24; startup_sel = 2'd2;
    @(negedge clk); prog_req_n = 1'b0;
    repeat (FILT+1) @(negedge clk); prog_req_n = 1'b1;
    chk("R12 user value lost on reconfig", user_q, 0);
    chk("R2 done low during clear", done, 0);
    chk("R3 store cleared", cfg_q, 0);
    count_clear(n);
    chk("R5 pulse gives two clear passes", n, 2*CLR);
    repeat (6) @(negedge clk);
    chk("R6 no byte_ready while start held", byte_ready, 0);
    chk("R6 done low while waiting", done, 0);
    start_n = 1'b1;
    bidx = 0;
    send_byte(8'h3C, 16, 24);
    send_byte(8'h96, 16, 24);
    send_byte(8'hE1, 16, 24);
    watch_startup(2);
    chk("R9 byte store MSB first", cfg_q, 32'h3C96);
    chk("R10 queue drained after bytes", exp_q.size(), 0);

    byte_mode = 1'b0; keep_len = 16'd8; total_len = 16'd8; startup_sel = 2'd1;
    @(negedge clk); prog_req_n = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 still clearing while held", init_drive_low, 1);
    prog_req_n = 1'b1;
    count_clear(n);
    chk("R5 one more pass after release", (n >= CLR && n <= 2*CLR+3), 1);
    repeat (3) @(negedge clk);
    send_ser(64'h6D, 8, 8, 1'b1);
    watch_startup(1);
    chk("R8 full-length store", cfg_q, 32'h6D);

    @(negedge clk); rst_n = 1'b0; mode_n = 1'b1; other_low = 1'b1;
    keep_len = 16'd4; total_len = 16'd6; startup_sel = 2'd3;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    count_clear(n);
    chk("R4 slave power-up clear length", n, CLR);
    repeat (3) @(negedge clk);
    send_ser(64'h2D, 6, 4, 1'b1);
    watch_startup(3);
    chk("R7 slave loads with init held low", cfg_q, 32'hB);
    chk("R10 slave queue drained", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule